// File: doc/BRIEF.md
# Charge-Path Overcurrent Supervisor

This block supervises the charge path of a battery pack. An external analog comparator reports an overcurrent condition as a single-bit level; the block brings that level into its clock domain and requires it to stay asserted for a programmable qualification window before it counts as a real fault. The block also drives a 4-bit threshold code to the comparator. On the analog side that code sets a trip voltage of 25 mV plus 5 mV per step. Inside the block it is only a stored field.

Once a fault qualifies, a sticky detect flag is set. The flag can raise an interrupt and can force a FET-control output to its active level, with the output polarity chosen by software. The FET-control signal can also be combined with an external interrupt pin, whose sense is selectable. The flag stays set until software writes a restart command. All register writes are accepted only while the write-unlock input is high.

The qualification window is counted in ticks of a prescaler that divides the system clock. With the default divider a tick is 1 ms at 250 MHz. The window is 1 + 2 x code ticks, from 1 ms at code 0 to 31 ms at code 15.

Top module: `ocp_supervisor`

Register map. Address 0 is the control register: bits 3:0 hold the threshold code, bit 4 is the detect enable, bit 5 the interrupt enable, bit 6 the FET enable and bit 7 the FET polarity (1 = active-high). Address 1 is the timing register: bits 3:0 hold the window code, bit 4 is the external-OR enable, bit 5 the external polarity (1 = pass unchanged, 0 = invert), and bits 7:6 are unused. Address 2 is the status register: reading bit 0 returns the detect flag, and writing 1 to bit 0 restarts detection. Address 3 is unused.

## Requirements
- R1: After reset, all three registers read 0, `irq` is 0, `thr_code` is 0 and `fet_ctl` is 1, which is the inactive level for active-low polarity.
- R2: A write made while `wr_unlock` is 0 changes no register and does not restart detection.
- R3: Bits 3:0 of the control register drive `thr_code` directly and read back unchanged.
- R4: With detection enabled, the flag sets after the synchronized input has stayed high for 1 + 2 x code ticks, where one tick is CLK_PER_TICK clocks and the code is timing bits 3:0.
- R5: If the synchronized input falls before the window completes, the count returns to zero, so separate short pulses never add up to a detection.
- R6: While detect enable (control bit 4) is 0, the flag cannot set.
- R7: `irq` is 1 one clock after the flag is 1 while interrupt enable (control bit 5) is 1, and 0 otherwise.
- R8: The FET term is the flag ANDed with FET enable (control bit 6). `fet_ctl` is the active term when control bit 7 is 1, and its inverse when bit 7 is 0.
- R9: When timing bit 4 is 1, the active term also includes the external pin. The pin is taken as-is when timing bit 5 is 1 and inverted when bit 5 is 0.
- R10: Writing 1 to status bit 0 clears the flag and the count together. Writing 0 has no effect. If the input is still high, a new full window is required before the flag sets again.
- R11: Unused bits read back as 0: timing bits 7:6, status bits 7:1, and every bit at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_unlock | input | 1 | Protect release; writes count only while high |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data, one clock after the address |
| oc_in | input | 1 | Asynchronous comparator trip level |
| ext_in | input | 1 | Asynchronous external interrupt pin |
| thr_code | output | 4 | Threshold code to the comparator DAC |
| irq | output | 1 | Registered interrupt request |
| fet_ctl | output | 1 | Registered FET control output |

## Verification
A vector table runs the FET output through its polarity, enable, external-OR and external-polarity combinations, first with the flag clear and then with it set. This tells a swapped polarity apart from a missing enable or a wrong external sense. The comparator input is held for just under and just over the window at codes 0, 3 and 15, which catches a wrong window formula. It is also pulsed in two sub-window pieces whose total exceeds the window, which shows whether the count really restarts. Restart is tried with a zero write, with a locked write, and with the input still high, which separates a real re-arm from a flag that never set again.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int CODE_W = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_TCFG = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  typedef struct packed {
    logic              fet_pol;
    logic              fet_en;
    logic              irq_en;
    logic              det_en;
    logic [CODE_W-1:0] thr;
  } ctrl_t;

  typedef struct packed {
    logic [1:0]        rsv;
    logic              ext_pol;
    logic              or_en;
    logic [CODE_W-1:0] code;
  } tcfg_t;
endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ocp_tick.sv
module ocp_tick #(
  parameter int DIV = 250000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  generate
    if (DIV > 1) begin : g_spacing
      // R4: a tick is one clock wide when the divider exceeds one
      p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/ocp_qualify.sv
module ocp_qualify #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              oc_s,
  input  logic              det_en,
  input  logic [CODE_W-1:0] code,
  input  logic              restart,
  output logic              flag
);
  localparam int CNT_W = CODE_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;

  // window length in ticks: 2*code + 1
  assign target = {code, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (!det_en || !oc_s || flag) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt >= target - 1'b1) begin
        flag <= 1'b1;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_restart_clears_r10: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!flag && cnt == '0));

  p_disabled_no_set_r6: assert property (@(posedge clk) disable iff (rst)
    (!det_en && !flag) |=> !flag);

  p_drop_clears_count_r5: assert property (@(posedge clk) disable iff (rst)
    !oc_s |=> cnt == '0);

  p_set_needs_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (!flag && !tick) |=> !flag);
endmodule

// File: rtl/ocp_supervisor.sv
module ocp_supervisor #(
  parameter int CLK_PER_TICK = 250000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_unlock,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       oc_in,
  input  logic       ext_in,
  output logic [3:0] thr_code,
  output logic       irq,
  output logic       fet_ctl
);
  import ocp_pkg::*;

  ctrl_t ctrl_q;
  tcfg_t tcfg_q;
  logic  wr_ok, restart, tick, flag;
  logic  oc_s, ext_s, ext_act, fet_act;
  logic [1:0] sync_q;

  assign wr_ok   = wr_en & wr_unlock;
  assign restart = wr_ok && (wr_addr == A_STAT) && wr_data[0];

  ocp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({ext_in, oc_in}), .q(sync_q)
  );
  assign oc_s  = sync_q[0];
  assign ext_s = sync_q[1];

  ocp_tick #(.DIV(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  ocp_qualify #(.CODE_W(CODE_W)) u_qual (
    .clk(clk), .rst(rst), .tick(tick), .oc_s(oc_s),
    .det_en(ctrl_q.det_en), .code(tcfg_q.code),
    .restart(restart), .flag(flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      tcfg_q <= '0;
    end else if (wr_ok) begin
      case (wr_addr)
        A_CTRL:  ctrl_q <= ctrl_t'(wr_data);
        A_TCFG:  tcfg_q <= tcfg_t'({2'b00, wr_data[5:0]});
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_CTRL:  rd_data <= ctrl_q;
        A_TCFG:  rd_data <= tcfg_q;
        A_STAT:  rd_data <= {7'b0, flag};
        default: rd_data <= '0;
      endcase
    end
  end

  assign ext_act = tcfg_q.ext_pol ? ext_s : ~ext_s;
  assign fet_act = (flag & ctrl_q.fet_en) | (tcfg_q.or_en & ext_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      fet_ctl <= 1'b1;
      irq     <= 1'b0;
    end else begin
      fet_ctl <= ctrl_q.fet_pol ? fet_act : ~fet_act;
      irq     <= flag & ctrl_q.irq_en;
    end
  end

  assign thr_code = ctrl_q.thr;

  p_locked_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_unlock) |=> ($stable(ctrl_q) && $stable(tcfg_q)));

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (rst)
    (flag && ctrl_q.irq_en) |=> irq);

  p_fet_idle_level_r8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.fet_en && !tcfg_q.or_en && !wr_ok) |=> (fet_ctl == !ctrl_q.fet_pol));

  p_unused_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_TCFG) |=> (rd_data[7:6] == 2'b00));
endmodule

// File: tb/ocp_supervisor_tb.sv
`timescale 1ns/1ps
module ocp_supervisor_tb;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_unlock = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       oc_in = 1'b0, ext_in = 1'b0;
  logic [3:0] thr_code;
  logic       irq, fet_ctl;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ocp_supervisor #(.CLK_PER_TICK(P)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_unlock(wr_unlock),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .oc_in(oc_in), .ext_in(ext_in), .thr_code(thr_code), .irq(irq), .fet_ctl(fet_ctl)
  );

  // {fet_pol, fet_en, or_en, ext_pol, ext_in, exp_flag0, exp_flag1}
  localparam logic [6:0] VEC [9] = '{
    7'b1100001, 7'b0100010, 7'b1000000, 7'b0001111, 7'b1011111,
    7'b1011000, 7'b1110011, 7'b0110110, 7'b0010000
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic unl);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_unlock = unl;
    step(1);
    wr_en = 1'b0; wr_unlock = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    step(1);
    d = rd_data;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    step(3);
    rst = 1'b0;
    step(1);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 tcfg", v, 8'h00);
    rd(2'd2, v); chk("R1 stat", v, 8'h00);
    chk("R1 fet", fet_ctl, 1'b1);
    chk("R1 irq", irq, 1'b0);
    chk("R1 thr", thr_code, 4'h0);

    // R2 locked write ignored
    wr(2'd0, 8'hFF, 1'b0);
    rd(2'd0, v); chk("R2 locked ctrl", v, 8'h00);
    chk("R2 thr", thr_code, 4'h0);

    // R3 threshold code, R11 unused bits
    wr(2'd0, 8'h0A, 1'b1);
    chk("R3 thr", thr_code, 4'hA);
    rd(2'd0, v); chk("R3 ctrl readback", v, 8'h0A);
    wr(2'd1, 8'hFF, 1'b1);
    rd(2'd1, v); chk("R11 tcfg unused", v, 8'h3F);
    rd(2'd3, v); chk("R11 addr3", v, 8'h00);
    wr(2'd1, 8'h00, 1'b1);

    // R6 detection disabled
    wr(2'd0, 8'h00, 1'b1);
    oc_in = 1'b1; step(60);
    rd(2'd2, v); chk("R6 no flag when disabled", v, 8'h00);
    oc_in = 1'b0; step(4);

    // R4 code 3: window 7 ticks, with R7 interrupt
    wr(2'd1, 8'h03, 1'b1);
    wr(2'd0, 8'h30, 1'b1);
    oc_in = 1'b1;
    step(6 * P);
    chk("R4 code3 before window", irq, 1'b0);
    step(12);
    chk("R4 R7 code3 after window irq", irq, 1'b1);
    rd(2'd2, v); chk("R4 stat flag", v, 8'h01);
    wr(2'd0, 8'h10, 1'b1);
    step(1);
    chk("R7 irq masked", irq, 1'b0);

    // R8 FET active-high with flag set
    wr(2'd0, 8'hD0, 1'b1);
    step(1);
    chk("R8 fet active", fet_ctl, 1'b1);

    // R10 restart behaviour
    wr(2'd2, 8'h00, 1'b1);
    rd(2'd2, v); chk("R10 zero write no effect", v, 8'h01);
    wr(2'd2, 8'h01, 1'b0);
    rd(2'd2, v); chk("R2 R10 locked restart ignored", v, 8'h01);
    wr(2'd2, 8'h01, 1'b1);
    rd(2'd2, v); chk("R10 restart clears", v, 8'h00);
    chk("R10 fet inactive after restart", fet_ctl, 1'b0);
    step(7 * P + 4);
    rd(2'd2, v); chk("R10 requalify", v, 8'h01);
    oc_in = 1'b0;
    wr(2'd2, 8'h01, 1'b1);
    step(4);

    // R5 split pulses never add up
    oc_in = 1'b1; step(40);
    oc_in = 1'b0; step(10);
    oc_in = 1'b1; step(40);
    oc_in = 1'b0;
    rd(2'd2, v); chk("R5 split pulses", v, 8'h00);
    step(4);

    // R4 code 15 boundary (31 ticks)
    wr(2'd1, 8'h0F, 1'b1);
    oc_in = 1'b1;
    step(30 * P);
    rd(2'd2, v); chk("R4 code15 before window", v, 8'h00);
    step(12);
    rd(2'd2, v); chk("R4 code15 after window", v, 8'h01);
    oc_in = 1'b0;
    wr(2'd2, 8'h01, 1'b1);
    step(4);

    // R4 code 0 boundary (1 tick)
    wr(2'd1, 8'h00, 1'b1);
    oc_in = 1'b1;
    step(P + 4);
    rd(2'd2, v); chk("R4 code0 after window", v, 8'h01);
    oc_in = 1'b0;
    wr(2'd2, 8'h01, 1'b1);
    step(4);

    // R8 R9 table, flag clear then flag set
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin
        wr(2'd1, 8'h00, 1'b1);
        wr(2'd0, 8'h10, 1'b1);
        oc_in = 1'b1;
        step(P + 4);
      end
      for (int i = 0; i < 9; i++) begin
        wr(2'd0, {VEC[i][6], VEC[i][5], 6'b010000}, 1'b1);
        wr(2'd1, {2'b00, VEC[i][3], VEC[i][4], 4'h0}, 1'b1);
        ext_in = VEC[i][2];
        step(5);
        chk($sformatf("R8 R9 vec%0d flag%0d", i, pass), fet_ctl,
            pass == 0 ? VEC[i][1] : VEC[i][0]);
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule